// File: doc/BRIEF.md
# Bitwise Lookup-Table Logic Unit

This unit is a 64-bit logic stage in which every bit position behaves like a tiny programmable lookup table. All lanes are evaluated in parallel with one shared truth table, so a single operation can produce any two- or three-input Boolean function of whole words. One truth table is an 8-entry table taken from an immediate, which gives any three-input function. The other is a 4-entry table picked at run time, which gives any two-input function.

Four modes are available. Ternary immediate mode uses the old destination word as its third input and returns the word that replaces it. Binary register mode takes its 4-entry table from the low or high nibble of a table byte. Binary field mode takes its table from a 4-bit condition field. Field ternary mode evaluates a three-input table on three 4-bit condition fields and merges the result under a write mask. The combinational result is captured in one output register, and a valid flag runs alongside it.

Top module: `lut_logic_unit`

## Requirements
- R1: When mode is 2'b00, result bit i equals imm[idx] with idx = {dst_old[i], opa[i], opb[i]} (dst_old in index bit 2, opa in bit 1, opb in bit 0). The result is the replacement value for the old destination word.
- R2: out_valid equals in_valid delayed by one clock. The result of an operation accepted at a rising edge appears on res at that same edge.
- R3: When mode is 2'b01, result bit i equals T[{opa[i], opb[i]}], where T is tbl_byte[3:0] when nib_sel is 0 and tbl_byte[7:4] when nib_sel is 1. The unselected nibble has no effect.
- R4: When mode is 2'b10, result bit i equals cf_table[{opa[i], opb[i]}]. tbl_byte and nib_sel have no effect in this mode.
- R5: When mode is 2'b11, the 4-bit result field is formed as follows. Each bit k with cf_mask[k]=1 equals imm[{dst_old[k], opa[k], opb[k]}] for k in 0..3. Each bit with cf_mask[k]=0 keeps dst_old[k]. res[63:4] is zero.
- R6: While rst_n is low, res is zero and out_valid is zero.
- R7: When in_valid is low at a rising edge, res keeps its previous value.
- R8: All 64 lanes are independent: any bit pattern of the operands gives each lane's function without cross-lane influence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| mode | input | 2 | 00 ternary imm, 01 binary nibble, 10 binary field, 11 field ternary |
| opa | input | 64 | First operand (index bit 1) |
| opb | input | 64 | Second operand (index bit 0) |
| dst_old | input | 64 | Current destination value (index bit 2, merge source) |
| imm | input | 8 | Three-input truth table |
| tbl_byte | input | 8 | Byte holding two candidate 4-entry tables |
| nib_sel | input | 1 | Picks the high (1) or low (0) nibble of tbl_byte |
| cf_table | input | 4 | Condition field used as a 4-entry table |
| cf_mask | input | 4 | Write mask for field ternary mode |
| res | output | 64 | Registered result |
| out_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
A bad table index, such as swapped operand roles or a wrong bit order, changes only the lanes whose input triple hits an asymmetric table entry. Random operands with random tables expose it on res in the cycle right after the operation. A wrong nibble or mask choice shows the same way: unselected table bits or masked field bits leak onto res at once. A stale output register shows as res changing on idle cycles, or as out_valid drifting from in_valid by one cycle.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic [1:0] {
    MODE_TERN    = 2'b00,
    MODE_BIN_REG = 2'b01,
    MODE_BIN_CF  = 2'b10,
    MODE_CF_TERN = 2'b11
  } lut_mode_e;

  // three-input table lookup, table bit index {c,b,a}
  function automatic logic lut3_eval(input logic [7:0] tbl, input logic a,
                                     input logic b, input logic c);
    return tbl[{c, b, a}];
  endfunction

  // two-input table lookup, table bit index {b,a}
  function automatic logic lut2_eval(input logic [3:0] tbl, input logic a,
                                     input logic b);
    return tbl[{b, a}];
  endfunction
endpackage

// File: rtl/lut_table_pick.sv
module lut_table_pick #(
  parameter int TBL_W = 4
) (
  input  logic [1:0]         mode,
  input  logic [2*TBL_W-1:0] tbl_byte,
  input  logic               nib_sel,
  input  logic [TBL_W-1:0]   cf_table,
  output logic [TBL_W-1:0]   tbl2
);
  import lut_pkg::*;
  logic [TBL_W-1:0] nibble;

  assign nibble = nib_sel ? tbl_byte[2*TBL_W-1:TBL_W] : tbl_byte[TBL_W-1:0];
  assign tbl2   = (lut_mode_e'(mode) == MODE_BIN_CF) ? cf_table : nibble;
endmodule

// File: rtl/lut_lane_array.sv
module lut_lane_array #(
  parameter int WIDTH = 64
) (
  input  logic [7:0]       tbl3,
  input  logic [3:0]       tbl2,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] dst_old,
  output logic [WIDTH-1:0] tern_out,
  output logic [WIDTH-1:0] bin_out
);
  import lut_pkg::*;
  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    assign tern_out[i] = lut3_eval(tbl3, opb[i], opa[i], dst_old[i]);
    assign bin_out[i]  = lut2_eval(tbl2, opb[i], opa[i]);
  end
endmodule

// File: rtl/lut_cf_merge.sv
module lut_cf_merge #(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] new_field,
  input  logic [FIELD_W-1:0] old_field,
  input  logic [FIELD_W-1:0] mask,
  output logic [FIELD_W-1:0] merged
);
  for (genvar k = 0; k < FIELD_W; k++) begin : g_bit
    assign merged[k] = mask[k] ? new_field[k] : old_field[k];
  end
endmodule

// File: rtl/lut_logic_unit.sv
module lut_logic_unit #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         mode,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  input  logic [DATA_W-1:0]  dst_old,
  input  logic [7:0]         imm,
  input  logic [7:0]         tbl_byte,
  input  logic               nib_sel,
  input  logic [FIELD_W-1:0] cf_table,
  input  logic [FIELD_W-1:0] cf_mask,
  output logic [DATA_W-1:0]  res,
  output logic               out_valid
);
  import lut_pkg::*;
  localparam int PAD_W = DATA_W - FIELD_W;

  logic [FIELD_W-1:0] tbl2_w;
  logic [DATA_W-1:0]  tern_w;
  logic [DATA_W-1:0]  bin_w;
  logic [FIELD_W-1:0] cf_merged_w;
  logic [DATA_W-1:0]  next_res;

  lut_table_pick #(.TBL_W(FIELD_W)) u_pick (
    .mode(mode), .tbl_byte(tbl_byte), .nib_sel(nib_sel),
    .cf_table(cf_table), .tbl2(tbl2_w)
  );

  lut_lane_array #(.WIDTH(DATA_W)) u_lanes (
    .tbl3(imm), .tbl2(tbl2_w), .opa(opa), .opb(opb), .dst_old(dst_old),
    .tern_out(tern_w), .bin_out(bin_w)
  );

  lut_cf_merge #(.FIELD_W(FIELD_W)) u_merge (
    .new_field(tern_w[FIELD_W-1:0]), .old_field(dst_old[FIELD_W-1:0]),
    .mask(cf_mask), .merged(cf_merged_w)
  );

  always_comb begin
    case (lut_mode_e'(mode))
      MODE_TERN:    next_res = tern_w;
      MODE_CF_TERN: next_res = {{PAD_W{1'b0}}, cf_merged_w};
      default:      next_res = bin_w;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res <= next_res;
    end
  end
endmodule

// File: rtl/lut_logic_checker.sv
module lut_logic_checker #(
  parameter int DATA_W  = 64,
  parameter int FIELD_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [1:0]         mode,
  input logic [DATA_W-1:0]  opa,
  input logic [DATA_W-1:0]  opb,
  input logic [DATA_W-1:0]  dst_old,
  input logic [7:0]         imm,
  input logic [7:0]         tbl_byte,
  input logic               nib_sel,
  input logic [FIELD_W-1:0] cf_table,
  input logic [FIELD_W-1:0] cf_mask,
  input logic [DATA_W-1:0]  res,
  input logic               out_valid
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));

  p_tern_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00 && imm == 8'hFF) |=> (res == '1));

  p_nibble_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b01 &&
     (nib_sel ? tbl_byte[7:4] : tbl_byte[3:0]) == 4'b1010) |=> (res == $past(opb)));

  p_cf_table_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b10 && cf_table == 4'b1100) |=> (res == $past(opa)));

  p_mask_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=>
      (((res[FIELD_W-1:0] ^ $past(dst_old[FIELD_W-1:0])) & ~$past(cf_mask)) == '0
       && res[DATA_W-1:FIELD_W] == '0));
endmodule

bind lut_logic_unit lut_logic_checker #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (.*);

// File: tb/tb_lut_logic_unit.sv
`timescale 1ns/1ps
module tb_lut_logic_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [63:0] opa = '0, opb = '0, dst_old = '0;
  logic [7:0]  imm = '0, tbl_byte = '0;
  logic        nib_sel = 1'b0;
  logic [3:0]  cf_table = '0, cf_mask = '0;
  logic [63:0] res;
  logic        out_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lut_logic_unit dut (.*);

  // expected result, computed lane by lane from the requirement text
  function automatic logic [63:0] model(input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input logic [7:0] t3,
      input logic [7:0] tb, input logic ns, input logic [3:0] ct, input logic [3:0] mk);
    logic [63:0] r = '0;
    logic [3:0]  t2 = ns ? (tb >> 4) : (tb & 8'h0F);
    for (int i = 0; i < 64; i++) begin
      int idx3 = (d[i] ? 4 : 0) + (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
      int idx2 = (a[i] ? 2 : 0) + (b[i] ? 1 : 0);
      case (m)
        2'b00: r[i] = t3[idx3];
        2'b01: r[i] = t2[idx2];
        2'b10: r[i] = ct[idx2];
        default: if (i < 4) r[i] = mk[i] ? t3[idx3] : d[i];
      endcase
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [1:0] m, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d, input logic [7:0] t3,
      input logic [7:0] tb, input logic ns, input logic [3:0] ct, input logic [3:0] mk);
    @(negedge clk);
    mode = m; opa = a; opb = b; dst_old = d; imm = t3; tbl_byte = tb;
    nib_sel = ns; cf_table = ct; cf_mask = mk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, res, model(m, a, b, d, t3, tb, ns, ct, mk));
    check("R2 out_valid", {63'b0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R6 res in reset", res, 64'd0);
    check("R6 out_valid in reset", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;

    // R1: all eight index combinations in separate lanes, majority and xor3
    run_op("R1 majority", 2'b00, 64'hCC, 64'hAA, 64'hF0, 8'hE8, 8'h00, 0, 4'h0, 4'h0);
    run_op("R1 xor3", 2'b00, 64'hCC, 64'hAA, 64'hF0, 8'h96, 8'h00, 0, 4'h0, 4'h0);
    run_op("R1 one-hot entry 5", 2'b00, 64'hCC, 64'hAA, 64'hF0, 8'h20, 8'h00, 0, 4'h0, 4'h0);
    // R3: nibble select, other nibble must not matter
    run_op("R3 low nibble", 2'b01, 64'hCC, 64'hAA, '0, 8'h00, 8'hF8, 0, 4'h0, 4'h0);
    run_op("R3 high nibble", 2'b01, 64'hCC, 64'hAA, '0, 8'h00, 8'h6F, 1, 4'h0, 4'h0);
    // R4: field table, tbl_byte set to a contrary table
    run_op("R4 field table and", 2'b10, 64'hCC, 64'hAA, '0, 8'h00, 8'hEE, 1, 4'h8, 4'h0);
    // R5: mask corners
    run_op("R5 mask none", 2'b11, 64'hC, 64'hA, 64'hFFFF_FFFF_FFFF_FFF5, 8'hFF, 8'h00, 0, 4'h0, 4'h0);
    run_op("R5 mask all", 2'b11, 64'hFC, 64'hFA, 64'hF0, 8'h96, 8'h00, 0, 4'h0, 4'hF);
    run_op("R5 mask partial", 2'b11, 64'hC, 64'hA, 64'h5, 8'hE8, 8'h00, 0, 4'h0, 4'h6);

    // R7: idle cycle with changed inputs leaves res alone
    held = res;
    @(negedge clk);
    opa = r64(); opb = r64(); mode = 2'b01; tbl_byte = 8'h55;
    @(negedge clk);
    check("R7 idle hold", res, held);
    check("R2 out_valid low", {63'b0, out_valid}, 64'd0);

    // R8: random lanes in every mode
    for (int n = 0; n < 300; n++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      run_op("R8 random", m, r64(), r64(), r64(), 8'($urandom()), 8'($urandom()),
             1'($urandom()), 4'($urandom()), 4'($urandom()));
    end

    // R6: reset mid-stream clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 res after reset", res, 64'd0);
    check("R6 out_valid after reset", {63'b0, out_valid}, 64'd0);
    rst_n = 1'b1;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule